// File: doc/BRIEF.md
# Save-RAM Lane Controller

This block places a small battery-backed byte memory behind a 16-bit big-endian host bus. The memory may be wired to both byte lanes of the bus, to the upper (even-address) lane only, or to the lower (odd-address) lane only. With single-lane wiring the RAM holds one byte per bus word, so the byte index is halved and the lane with no RAM behind it reads as all ones.

A bank of small control registers sits at its own address range. Register 0 decides whether the shared window shows the save RAM or the external ROM, and whether writes reach the RAM at all. The remaining registers are stored and brought out to drive the rest of the cartridge mapping. The host issues one access per request cycle, a read answers one cycle later, and the byte enables pick the lanes that a write touches.

Top module: `sram_lane_ctrl`

## Requirements
- R1: After reset all control registers read 0 on `bank_regs`, `rvalid` is low, the window shows ROM and window writes are disabled.
- R2: A read request (`req`=1, `we`=0) gives `rvalid`=1 with `rdata` in the next cycle only. Every read returns a full 16-bit word, whatever `be` holds.
- R3: For a read inside the window (0x200000 to 0x3FFFFF), bit 0 of register 0 picks the source. When the bit is 0, the read returns `rom_word` as sampled in the request cycle. When the bit is 1, the read returns save-RAM data.
- R4: A window write reaches the RAM only while bits [1:0] of register 0 equal 2'b01.
- R5: The byte offset is `{addr[23:1],0} & addr_mask`. The RAM index is taken modulo the RAM size (256 bytes by default).
- R6: Lane mode 0 (and 3) uses both lanes. `be[1]` writes `wdata[15:8]` to RAM[offset] and `be[0]` writes `wdata[7:0]` to RAM[offset+1]. A read returns {RAM[offset], RAM[offset+1]}.
- R7: Lane mode 1 wires the even lane only. The index is offset>>1 and data sits in the upper byte. The lower byte reads 0xFF, and a `be[0]` write is ignored.
- R8: Lane mode 2 wires the odd lane only. The index is offset>>1 and data sits in the lower byte. The upper byte reads 0xFF, and a `be[1]` write is ignored.
- R9: Control registers decode at 0xA13000 to 0xA130FF. The register index is `addr[3:1]` and the value written is `wdata[7:0]`. A write without `be[0]` (even byte only) changes nothing. Register i appears on `bank_regs[8i+7:8i]`. Reads of this range return 0xFFFF.
- R10: An access outside both ranges writes nothing and reads 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Access request this cycle |
| we | input | 1 | 1 = write, 0 = read |
| be | input | 2 | Byte enables: [1] upper/even lane, [0] lower/odd lane |
| addr | input | 24 | Host byte address |
| wdata | input | 16 | Write data, big-endian |
| lane_mode | input | 2 | 0/3 both lanes, 1 even lane only, 2 odd lane only |
| addr_mask | input | 9 | Offset mask (RAM span minus one) |
| rom_word | input | 16 | ROM data returned while the window shows ROM |
| rdata | output | 16 | Read data |
| rvalid | output | 1 | Read data valid |
| bank_regs | output | 64 | Control registers, register i at bits [8i+7:8i] |

## Verification
A corrupted control register shows up on `bank_regs` at once. It also shows up in the next read of the window, which flips between ROM and RAM data or loses writes that should have landed. A wrong lane index does not show up at the moment of the write. It shows up later, when the same RAM byte is read back through a different lane mode or address alias and the pattern does not match. A fill-byte or valid-timing fault shows on the very next read response.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

  typedef enum logic [1:0] {
    LANE_BOTH  = 2'd0,
    LANE_EVEN  = 2'd1,
    LANE_ODD   = 2'd2,
    LANE_BOTH2 = 2'd3
  } lane_e;

  localparam logic [7:0] FILL_BYTE = 8'hFF;

  // upper bus lane has RAM behind it
  function automatic logic hi_wired(lane_e m);
    return m != LANE_ODD;
  endfunction

  // lower bus lane has RAM behind it
  function automatic logic lo_wired(lane_e m);
    return m != LANE_EVEN;
  endfunction

  // single-lane wiring halves the index
  function automatic logic split_index(lane_e m);
    return (m == LANE_EVEN) || (m == LANE_ODD);
  endfunction

  function automatic logic [15:0] join_lanes(lane_e m, logic [7:0] hi, logic [7:0] lo);
    logic [7:0] h;
    logic [7:0] l;
    h = hi_wired(m) ? hi : FILL_BYTE;
    l = lo_wired(m) ? lo : FILL_BYTE;
    return {h, l};
  endfunction

endpackage

// File: rtl/sram_lane_decode.sv
module sram_lane_decode #(
  parameter int unsigned ADDR_W    = 24,
  parameter int unsigned OFF_W     = 9,
  parameter int unsigned BIDX_W    = 3,
  parameter logic [ADDR_W-1:0] WIN_BASE  = 24'h200000,
  parameter int unsigned       WIN_LEN   = 32'h200000,
  parameter logic [ADDR_W-1:0] BANK_BASE = 24'hA13000,
  parameter int unsigned       BANK_LEN  = 32'h100
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [OFF_W-1:0]  addr_mask,
  output logic              win_hit,
  output logic              bank_hit,
  output logic [OFF_W-1:0]  offset,
  output logic [BIDX_W-1:0] bank_idx
);
  localparam logic [ADDR_W:0] WIN_LO  = {1'b0, WIN_BASE};
  localparam logic [ADDR_W:0] WIN_HI  = {1'b0, WIN_BASE} + (ADDR_W+1)'(WIN_LEN);
  localparam logic [ADDR_W:0] BANK_LO = {1'b0, BANK_BASE};
  localparam logic [ADDR_W:0] BANK_HI = {1'b0, BANK_BASE} + (ADDR_W+1)'(BANK_LEN);

  logic [ADDR_W:0] addr_x;
  assign addr_x   = {1'b0, addr};
  assign win_hit  = (addr_x >= WIN_LO) && (addr_x < WIN_HI);
  assign bank_hit = (addr_x >= BANK_LO) && (addr_x < BANK_HI);

  // word-aligned offset, masked to the RAM span
  assign offset   = {addr[OFF_W-1:1], 1'b0} & addr_mask;
  assign bank_idx = addr[BIDX_W:1];
endmodule

// File: rtl/sram_lane_bank.sv
module sram_lane_bank #(
  parameter int unsigned NUM_BANK = 8,
  parameter int unsigned BANK_W   = 8,
  parameter int unsigned BIDX_W   = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr,
  input  logic [BIDX_W-1:0]          idx,
  input  logic                       lo_lane,
  input  logic [BANK_W-1:0]          wdata,
  output logic [NUM_BANK*BANK_W-1:0] bank_flat
);
  // a register only takes the odd (lower) byte
  logic commit;
  assign commit = wr && lo_lane;

  for (genvar g = 0; g < NUM_BANK; g++) begin : g_reg
    logic [BANK_W-1:0] val;
    always_ff @(posedge clk) begin
      if (rst)                                  val <= '0;
      else if (commit && idx == BIDX_W'(g))     val <= wdata;
    end
    assign bank_flat[g*BANK_W +: BANK_W] = val;
  end
endmodule

// File: rtl/sram_lane_store.sv
module sram_lane_store
  import sram_lane_pkg::*;
#(
  parameter int unsigned RAM_BYTES = 256,
  parameter int unsigned RIDX_W    = $clog2(RAM_BYTES),
  parameter int unsigned OFF_W     = RIDX_W + 1
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [1:0]        be,
  input  lane_e             mode,
  input  logic [OFF_W-1:0]  offset,
  input  logic [15:0]       wdata,
  output logic [15:0]       rd_word,
  output logic              wr_hi_fire,
  output logic              wr_lo_fire
);
  logic [7:0] mem [RAM_BYTES];

  logic [RIDX_W-1:0] idx_pair;
  logic [RIDX_W-1:0] idx_pair_n;
  logic [RIDX_W-1:0] idx_half;
  logic [RIDX_W-1:0] hi_idx;
  logic [RIDX_W-1:0] lo_idx;

  assign idx_pair   = offset[RIDX_W-1:0];
  assign idx_pair_n = idx_pair + 1'b1;
  assign idx_half   = offset[RIDX_W:1];
  assign hi_idx     = split_index(mode) ? idx_half : idx_pair;
  assign lo_idx     = split_index(mode) ? idx_half : idx_pair_n;

  assign wr_hi_fire = wr_en && be[1] && hi_wired(mode);
  assign wr_lo_fire = wr_en && be[0] && lo_wired(mode);

  always_ff @(posedge clk) begin
    if (wr_hi_fire) mem[hi_idx] <= wdata[15:8];
    if (wr_lo_fire) mem[lo_idx] <= wdata[7:0];
  end

  assign rd_word = join_lanes(mode, mem[hi_idx], mem[lo_idx]);
endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
  import sram_lane_pkg::*;
#(
  parameter int unsigned ADDR_W    = 24,
  parameter int unsigned RAM_BYTES = 256,
  parameter int unsigned NUM_BANK  = 8,
  parameter int unsigned BANK_W    = 8,
  parameter logic [ADDR_W-1:0] WIN_BASE  = 24'h200000,
  parameter int unsigned       WIN_LEN   = 32'h200000,
  parameter logic [ADDR_W-1:0] BANK_BASE = 24'hA13000,
  parameter int unsigned       BANK_LEN  = 32'h100,
  localparam int unsigned RIDX_W = $clog2(RAM_BYTES),
  localparam int unsigned OFF_W  = RIDX_W + 1,
  localparam int unsigned BIDX_W = $clog2(NUM_BANK)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       req,
  input  logic                       we,
  input  logic [1:0]                 be,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [15:0]                wdata,
  input  logic [1:0]                 lane_mode,
  input  logic [OFF_W-1:0]           addr_mask,
  input  logic [15:0]                rom_word,
  output logic [15:0]                rdata,
  output logic                       rvalid,
  output logic [NUM_BANK*BANK_W-1:0] bank_regs
);
  lane_e mode;
  assign mode = lane_e'(lane_mode);

  logic              win_hit;
  logic              bank_hit;
  logic [OFF_W-1:0]  offset;
  logic [BIDX_W-1:0] bank_idx;

  sram_lane_decode #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .BIDX_W(BIDX_W),
    .WIN_BASE(WIN_BASE), .WIN_LEN(WIN_LEN),
    .BANK_BASE(BANK_BASE), .BANK_LEN(BANK_LEN)
  ) u_dec (
    .addr(addr), .addr_mask(addr_mask),
    .win_hit(win_hit), .bank_hit(bank_hit),
    .offset(offset), .bank_idx(bank_idx)
  );

  logic rd_req;
  logic wr_req;
  logic bank_wr;
  assign rd_req  = req && !we;
  assign wr_req  = req && we;
  assign bank_wr = wr_req && bank_hit;

  sram_lane_bank #(
    .NUM_BANK(NUM_BANK), .BANK_W(BANK_W), .BIDX_W(BIDX_W)
  ) u_bank (
    .clk(clk), .rst(rst), .wr(bank_wr), .idx(bank_idx),
    .lo_lane(be[0]), .wdata(wdata[BANK_W-1:0]), .bank_flat(bank_regs)
  );

  logic [BANK_W-1:0] bank0;
  logic              show_ram;
  logic              unlocked;
  assign bank0    = bank_regs[BANK_W-1:0];
  assign show_ram = bank0[0];
  assign unlocked = (bank0[1:0] == 2'b01);

  logic        win_wr;
  logic [15:0] ram_word;
  logic        wr_hi_fire;
  logic        wr_lo_fire;
  assign win_wr = wr_req && win_hit && unlocked;

  sram_lane_store #(
    .RAM_BYTES(RAM_BYTES), .RIDX_W(RIDX_W), .OFF_W(OFF_W)
  ) u_store (
    .clk(clk), .wr_en(win_wr), .be(be), .mode(mode), .offset(offset),
    .wdata(wdata), .rd_word(ram_word),
    .wr_hi_fire(wr_hi_fire), .wr_lo_fire(wr_lo_fire)
  );

  logic [15:0] resp_next;
  assign resp_next = !win_hit ? 16'hFFFF : (show_ram ? ram_word : rom_word);

  // registered response plus tags that the checks below rely on
  logic  src_ram_q;
  lane_e mode_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid    <= 1'b0;
      rdata     <= '0;
      src_ram_q <= 1'b0;
      mode_q    <= LANE_BOTH;
    end else begin
      rvalid <= rd_req;
      if (rd_req) begin
        rdata     <= resp_next;
        src_ram_q <= win_hit && show_ram;
        mode_q    <= mode;
      end
    end
  end

  a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (bank_regs == '0) && !rvalid);

  a_r2_rvalid_after_read: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> rvalid);

  a_r2_rvalid_only_on_read: assert property (@(posedge clk) disable iff (rst)
    !rd_req |=> !rvalid);

  a_r4_write_needs_unlock: assert property (@(posedge clk) disable iff (rst)
    (wr_hi_fire || wr_lo_fire) |-> (bank_regs[1:0] == 2'b01));

  a_r7_even_low_fill: assert property (@(posedge clk) disable iff (rst)
    (rvalid && src_ram_q && mode_q == LANE_EVEN) |-> (rdata[7:0] == 8'hFF));

  a_r8_odd_high_fill: assert property (@(posedge clk) disable iff (rst)
    (rvalid && src_ram_q && mode_q == LANE_ODD) |-> (rdata[15:8] == 8'hFF));

  a_r9_even_byte_ignored: assert property (@(posedge clk) disable iff (rst)
    (bank_wr && !be[0]) |=> $stable(bank_regs));

  a_r10_outside_no_write: assert property (@(posedge clk) disable iff (rst)
    (wr_req && !win_hit) |-> !(wr_hi_fire || wr_lo_fire));
endmodule

// File: tb/sim_sram_lane_ctrl.sv
module sim_sram_lane_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  be = 2'b00;
  logic [23:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [1:0]  lane_mode = 2'd0;
  logic [8:0]  addr_mask = 9'h0FF;
  logic [15:0] rom_word = 16'hA55A;
  logic [15:0] rdata;
  logic        rvalid;
  logic [63:0] bank_regs;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  sram_lane_ctrl u0 (
    .clk(clk), .rst(rst), .req(req), .we(we), .be(be), .addr(addr),
    .wdata(wdata), .lane_mode(lane_mode), .addr_mask(addr_mask),
    .rom_word(rom_word), .rdata(rdata), .rvalid(rvalid), .bank_regs(bank_regs)
  );

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive at a falling edge, sample one rising edge later at the next falling edge
  task automatic op(input logic w, input logic [23:0] a, input logic [1:0] b,
                    input logic [15:0] d, output logic [15:0] q, output logic v);
    req = 1'b1; we = w; addr = a; be = b; wdata = d;
    @(posedge clk);
    @(negedge clk);
    v = rvalid; q = rdata;
    req = 1'b0; we = 1'b0;
  endtask

  task automatic wr(input logic [23:0] a, input logic [1:0] b, input logic [15:0] d);
    logic [15:0] q;
    logic v;
    op(1'b1, a, b, d, q, v);
  endtask

  task automatic rd_chk(input logic [23:0] a, input logic [15:0] exp, input string tag);
    logic [15:0] q;
    logic v;
    op(1'b0, a, 2'b11, 16'h0, q, v);
    chk(v, "R2 rvalid on read", {63'h0, v}, 64'h1);
    chk(q == exp, tag, {48'h0, q}, {48'h0, exp});
  endtask

  task automatic set_bank0(input logic [7:0] v);
    wr(24'hA13000, 2'b11, {8'h00, v});
  endtask

  task automatic t_reset;
    chk(bank_regs == 64'h0, "R1 bank regs clear", bank_regs, 64'h0);
    chk(rvalid == 1'b0, "R1 rvalid low", {63'h0, rvalid}, 64'h0);
    rom_word = 16'hA55A;
    rd_chk(24'h200000, 16'hA55A, "R1 window shows ROM after reset");
    @(negedge clk);
    chk(rvalid == 1'b0, "R2 rvalid single cycle", {63'h0, rvalid}, 64'h0);
  endtask

  task automatic t_rom;
    set_bank0(8'h02);
    chk(bank_regs[7:0] == 8'h02, "R9 bank0 written", {56'h0, bank_regs[7:0]}, 64'h02);
    rom_word = 16'h3C3C;
    rd_chk(24'h200010, 16'h3C3C, "R3 bit0 clear selects ROM");
  endtask

  task automatic t_lock;
    lane_mode = 2'd0; addr_mask = 9'h0FF;
    set_bank0(8'h01);
    wr(24'h200020, 2'b11, 16'h1111);
    rd_chk(24'h200020, 16'h1111, "R3 bit0 set selects RAM");
    set_bank0(8'h03);
    wr(24'h200020, 2'b11, 16'h2222);
    rd_chk(24'h200020, 16'h1111, "R4 mode 11 blocks write");
    set_bank0(8'h00);
    wr(24'h200020, 2'b11, 16'h3333);
    set_bank0(8'h01);
    rd_chk(24'h200020, 16'h1111, "R4 mode 00 blocks write");
  endtask

  task automatic t_both;
    lane_mode = 2'd0;
    wr(24'h200040, 2'b11, 16'hBEEF);
    rd_chk(24'h200040, 16'hBEEF, "R6 word write/read");
    wr(24'h200041, 2'b01, 16'h0077);
    rd_chk(24'h200040, 16'hBE77, "R6 odd byte write");
    wr(24'h200040, 2'b10, 16'h5500);
    rd_chk(24'h200040, 16'h5577, "R6 even byte write");
    lane_mode = 2'd3;
    rd_chk(24'h200040, 16'h5577, "R6 mode 3 acts as both lanes");
  endtask

  task automatic t_even;
    lane_mode = 2'd1;
    wr(24'h200080, 2'b11, 16'hC3D4);
    rd_chk(24'h200080, 16'hC3FF, "R7 even lane, low fill");
    wr(24'h200080, 2'b01, 16'h0099);
    rd_chk(24'h200080, 16'hC3FF, "R7 low-lane write ignored");
    lane_mode = 2'd0;
    rd_chk(24'h200040, 16'hC377, "R7 halved index hits byte 0x40");
  endtask

  task automatic t_odd;
    lane_mode = 2'd2;
    wr(24'h200082, 2'b11, 16'h1E2F);
    rd_chk(24'h200082, 16'hFF2F, "R8 odd lane, high fill");
    wr(24'h200082, 2'b10, 16'hAB00);
    rd_chk(24'h200082, 16'hFF2F, "R8 high-lane write ignored");
    lane_mode = 2'd0;
    rd_chk(24'h200040, 16'hC32F, "R8 halved index hits byte 0x41");
  endtask

  task automatic t_mask;
    lane_mode = 2'd0;
    addr_mask = 9'h00F;
    wr(24'h200012, 2'b11, 16'h6655);
    addr_mask = 9'h0FF;
    rd_chk(24'h200002, 16'h6655, "R5 mask folds offset 0x12 to 0x02");
    addr_mask = 9'h1FF;
    wr(24'h200100, 2'b11, 16'h7788);
    addr_mask = 9'h0FF;
    rd_chk(24'h200000, 16'h7788, "R5 index wraps modulo RAM size");
  endtask

  task automatic t_bank;
    wr(24'hA1300A, 2'b11, 16'h00C1);
    chk(bank_regs[47:40] == 8'hC1, "R9 index from addr[3:1]", {56'h0, bank_regs[47:40]}, 64'hC1);
    wr(24'hA1300C, 2'b10, 16'h3300);
    chk(bank_regs[55:48] == 8'h00, "R9 even byte write ignored", {56'h0, bank_regs[55:48]}, 64'h0);
    wr(24'hA1300D, 2'b01, 16'h0044);
    chk(bank_regs[55:48] == 8'h44, "R9 odd byte write taken", {56'h0, bank_regs[55:48]}, 64'h44);
    rd_chk(24'hA13000, 16'hFFFF, "R9 register range reads all ones");
    wr(24'hA13100, 2'b11, 16'h0000);
    chk(bank_regs[7:0] == 8'h01, "R10 past register range ignored", {56'h0, bank_regs[7:0]}, 64'h01);
  endtask

  task automatic t_outside;
    lane_mode = 2'd0;
    wr(24'h200000, 2'b11, 16'h0102);
    wr(24'h100000, 2'b11, 16'hEEEE);
    rd_chk(24'h200000, 16'h0102, "R10 outside write has no effect");
    rd_chk(24'h100000, 16'hFFFF, "R10 outside read all ones");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_rom();
    t_lock();
    t_both();
    t_even();
    t_odd();
    t_mask();
    t_bank();
    t_outside();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule